// File: doc/BRIEF.md
# Chip-Enable Write-Protect Gate

This block sits between a host's active-low memory chip-enable and the memory itself. While the system is out of reset, the chip-enable goes straight through with no clock latency. When the supervisory reset flag asserts, the gate stops passing the strobe so that stray writes during a brownout cannot corrupt the memory.

An access that is already running when reset arrives is allowed to finish. The gate keeps the output low for a bounded grace window. That window closes after `GRACE_TICKS` clock cycles, or earlier if the input returns high. After that the output is forced inactive (high) until the reset flag drops. The reset flag is sampled on the block clock, and the chip-enable level seen on the edge where the flag is first sampled high decides between the grace path and the immediate-block path. A flag held high during battery backup therefore keeps the output high for the whole backup period.

Top module: `ce_gate`

## Requirements
- R1: After `rst_ni` is released with `hold_i` low, `ce_n_o` equals `ce_n_i`.
- R2: While the gate is in pass state (`hold_i` low, and at least one clock edge seen since it fell), `ce_n_o` equals `ce_n_i` combinationally, with no clock delay, for both levels.
- R3: If `ce_n_i` is 1 on the first clock edge that samples `hold_i` high, `ce_n_o` is 1 from that edge until `hold_i` falls, whatever `ce_n_i` does in between.
- R4: If `ce_n_i` is 0 on the first clock edge that samples `hold_i` high and stays 0, `ce_n_o` stays 0 for exactly `GRACE_TICKS` clock edges, counting that edge. It goes to 1 after the following edge.
- R5: If `ce_n_i` goes to 1 during the grace window, `ce_n_o` goes to 1 at once. It stays 1 even if `ce_n_i` returns to 0 while `hold_i` stays high.
- R6: Once the grace window has ended, `ce_n_o` is 1 until `hold_i` is sampled low, ignoring all `ce_n_i` transitions.
- R7: After `hold_i` falls, `ce_n_o` stays 1 until the next clock edge. From that edge on, it follows `ce_n_i` again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock; the grace window is counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low logic reset |
| ce_n_i | input | 1 | Active-low chip-enable from the host |
| hold_i | input | 1 | Supervisory reset flag; 1 means the system is held in reset |
| ce_n_o | output | 1 | Gated active-low chip-enable to the memory |

## Verification
The bench counts the grace window edge by edge. An off-by-one counter would release the strobe one cycle early or late, and a missing timer would never release it. It toggles the input during both the blocked state and the post-grace state. A gate that reopened on a later falling input would then leak a write strobe. It raises the input partway through the grace window and drops it again, which catches a design that ends the window only on timeout or that resumes following the input. It checks the cycle right after reset deassertion, and then after the first edge, so that a gate that reopens without waiting for the edge, or that adds a cycle of latency in pass state, shows a wrong level.

// File: rtl/ce_gate_pkg.sv
package ce_gate_pkg;
  typedef enum logic [1:0] {
    ST_PASS  = 2'd0,
    ST_GRACE = 2'd1,
    ST_BLOCK = 2'd2
  } gate_st_e;
endpackage

// File: rtl/ce_gate_timer.sv
module ce_gate_timer #(
  parameter int unsigned GRACE_TICKS = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = (GRACE_TICKS < 2) ? 1 : $clog2(GRACE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(GRACE_TICKS - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/ce_gate_fsm.sv
module ce_gate_fsm
  import ce_gate_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hold_i,
  input  logic     ce_n_i,
  input  logic     expired_i,
  output gate_st_e state_o
);
  gate_st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_PASS:  if (hold_i) state_d = ce_n_i ? ST_BLOCK : ST_GRACE;
      ST_GRACE: begin
        if (!hold_i)                    state_d = ST_PASS;
        else if (ce_n_i || expired_i)   state_d = ST_BLOCK;
      end
      ST_BLOCK: if (!hold_i) state_d = ST_PASS;
      default:  state_d = ST_BLOCK;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_PASS;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ce_gate.sv
module ce_gate
  import ce_gate_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 3000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_n_i,
  input  logic hold_i,
  output logic ce_n_o
);
  gate_st_e state;
  logic     expired;

  ce_gate_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold_i),
    .ce_n_i    (ce_n_i),
    .expired_i (expired),
    .state_o   (state)
  );

  ce_gate_timer #(.GRACE_TICKS(GRACE_TICKS)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (state == ST_GRACE),
    .expired_o (expired)
  );

  // pass and grace both route the input; block forces inactive
  assign ce_n_o = (state == ST_BLOCK) ? 1'b1 : ce_n_i;
endmodule

// File: rtl/ce_gate_chk.sv
module ce_gate_chk
  import ce_gate_pkg::*;
#(
  parameter int unsigned GRACE_TICKS = 3000
) (
  input logic     clk_i,
  input logic     rst_ni,
  input logic     ce_n_i,
  input logic     hold_i,
  input logic     ce_n_o,
  input gate_st_e state
);
  logic [31:0] grace_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                grace_cnt_q <= '0;
    else if (state == ST_GRACE) grace_cnt_q <= grace_cnt_q + 1;
    else                        grace_cnt_q <= '0;
  end

  // R2
  pass_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_i && !$past(hold_i)) |-> (ce_n_o == ce_n_i));

  // R3
  idle_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PASS && hold_i && ce_n_i) |=> ce_n_o);

  // R4
  grace_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_GRACE) |-> (grace_cnt_q < GRACE_TICKS));

  // R5
  early_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_GRACE && hold_i && ce_n_i) |=> ce_n_o);

  // R6
  stay_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && $past(hold_i) && $past(state) != ST_PASS && $past(ce_n_o)) |-> ce_n_o);

  // R7
  reopen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(hold_i) |-> (state == ST_PASS));
endmodule

bind ce_gate ce_gate_chk #(.GRACE_TICKS(GRACE_TICKS)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ce_n_i (ce_n_i),
  .hold_i (hold_i),
  .ce_n_o (ce_n_o),
  .state  (state)
);

// File: tb/ce_gate_tb.sv
module ce_gate_tb;
  localparam int unsigned GT = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ce_n_i = 1'b1;
  logic hold_i = 1'b0;
  logic ce_n_o;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ce_gate #(.GRACE_TICKS(GT)) u_dut (
    .clk_i (clk), .rst_ni (rst_ni), .ce_n_i (ce_n_i),
    .hold_i (hold_i), .ce_n_o (ce_n_o)
  );

  task automatic chk(input string req, input logic exp);
    checks++;
    if (ce_n_o !== exp) begin
      fails++;
      $display("FAIL %s ce_n_o actual=%b expected=%b t=%0t", req, ce_n_o, exp, $time);
    end
  endtask

  task automatic drive(input logic h, input logic c);
    @(negedge clk);
    hold_i = h;
    ce_n_i = c;
    #1;
  endtask

  task automatic t_reset;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    drive(1'b0, 1'b0); chk("R1", 1'b0);
    drive(1'b0, 1'b1); chk("R1", 1'b1);
  endtask

  task automatic t_pass;
    drive(1'b0, 1'b0); chk("R2", 1'b0);
    ce_n_i = 1'b1; #1; chk("R2", 1'b1);
    ce_n_i = 1'b0; #1; chk("R2", 1'b0);
    for (int i = 0; i < 6; i++) begin
      drive(1'b0, logic'(i % 2)); chk("R2", logic'(i % 2));
    end
  endtask

  task automatic release_gate(input string req);
    drive(1'b0, 1'b0); chk(req, 1'b1);
    @(negedge clk); #1; chk(req, 1'b0);
    ce_n_i = 1'b1; #1; chk(req, 1'b1);
  endtask

  task automatic t_idle_block;
    drive(1'b1, 1'b1);
    for (int i = 0; i < 8; i++) begin
      drive(1'b1, logic'(i % 2)); chk("R3", 1'b1);
    end
    release_gate("R7");
  endtask

  task automatic t_grace_timeout;
    drive(1'b1, 1'b0);
    for (int j = 0; j <= int'(GT); j++) begin
      @(negedge clk); #1;
      chk("R4", (j < int'(GT)) ? 1'b0 : 1'b1);
    end
    for (int i = 0; i < 6; i++) begin
      drive(1'b1, logic'(i % 2)); chk("R6", 1'b1);
    end
    release_gate("R7");
  endtask

  task automatic t_grace_early;
    drive(1'b1, 1'b0);
    repeat (4) begin @(negedge clk); #1; chk("R4", 1'b0); end
    ce_n_i = 1'b1; #1; chk("R5", 1'b1);
    drive(1'b1, 1'b0); chk("R5", 1'b1);
    for (int i = 0; i < int'(GT) + 2; i++) begin
      @(negedge clk); #1; chk("R5", 1'b1);
    end
    release_gate("R7");
  endtask

  initial begin
    t_reset();
    t_pass();
    t_idle_block();
    t_grace_timeout();
    t_grace_early();
    t_pass();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule